// File: doc/BRIEF.md
# Status register and write protection guard

This block holds the write-enable latch and the nonvolatile protection bits of a serial EEPROM: a two-bit block-protect level and a bit that arms the hardware write-protect pin. It also times the internal programming cycle. A command front-end feeds it one-clock strobes for the enable, disable and status-write commands, together with the chip-select level. The write engine feeds it a start strobe for array programming. Whenever a write is proposed, the block returns the status byte for a status read and two permission flags. One flag says whether the presented array address may be programmed. The other says whether the status register may be rewritten.

A status write is staged while chip select is low and starts its timed cycle when chip select rises. The new protection bits land when the cycle ends. Array and status writes share the same busy timer. At the end of either kind of cycle the write-enable latch is dropped. After reset the protection bits come from parameters, which stand in for contents stored earlier.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte is {WPEN_INIT, 3'b000, BP_INIT, 1'b0, 1'b0}, with bit 7 = protect-pin arm, bits 3:2 = block-protect level, bit 1 = write enable, bit 0 = busy.
- R2: A wren_stb pulse sets status bit 1 on the next clock. A wrdi_stb pulse clears it whatever the level of wp_n, and wrdi wins if both arrive together.
- R3: With write enable set and no cycle running, arr_ok is refused for the following addresses, and granted for all others. Level 00 refuses none. Level 01 refuses the top quarter, where the two upper address bits are both 1. Level 10 refuses the top half, where the upper bit is 1. Level 11 refuses every address.
- R4: While status bit 1 is 0, arr_ok and sreg_ok are both 0.
- R5: Hardware lock applies only when wp_n is 0 and bit 7 is 1. While it applies, sreg_ok is 0 and status-write strobes are ignored, but unprotected addresses stay writable. With bit 7 at 0, wp_n has no effect.
- R6: An accepted status write takes only bits 7, 3 and 2 of sr_din. The cycle starts on the first clock that sees cs_n high after it was low, and the new bits appear in the status byte when the cycle ends.
- R7: If the hardware lock comes on while cs_n is still low after a status write was accepted, that write is dropped, no cycle starts and the status is unchanged.
- R8: A cycle lasts CYC_LEN clocks. During it the status byte reads 8'hFF, both permissions are 0, and enable, disable and status-write strobes are ignored.
- R9: Write enable is 0 when a cycle ends.
- R10: arr_go starts a cycle only when write enable is 1 and no cycle runs; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, low while a command runs |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_stb | input | 1 | Set write enable |
| wrdi_stb | input | 1 | Clear write enable |
| wrsr_stb | input | 1 | Status write data valid |
| sr_din | input | 8 | Status byte to write |
| arr_go | input | 1 | Start an array programming cycle |
| chk_addr | input | AW | Address to judge for array permission |
| stat_byte | output | 8 | Status byte for reading |
| arr_ok | output | 1 | Array write at chk_addr allowed |
| sreg_ok | output | 1 | Status write allowed |

## Verification
The bench builds the default 15-bit address with CYC_LEN set to 12, so every programming cycle can be counted to its exact last busy clock. A second instance uses BP_INIT = 2'b11 and WPEN_INIT = 1, which brings the loading of stored contents at reset, and a fully protected array, within reach without any prior write. Walking the three protection levels through status writes places the quarter and half boundaries at 0x6000 and 0x4000, and the bench checks the addresses on both sides of each.

// File: rtl/sreg_guard.sv
module sreg_guard #(
  parameter int          AW        = 15,
  parameter int          CYC_LEN   = 20000,
  parameter logic [1:0]  BP_INIT   = 2'b00,
  parameter logic        WPEN_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          wren_stb,
  input  logic          wrdi_stb,
  input  logic          wrsr_stb,
  input  logic [7:0]    sr_din,
  input  logic          arr_go,
  input  logic [AW-1:0] chk_addr,
  output logic [7:0]    stat_byte,
  output logic          arr_ok,
  output logic          sreg_ok
);
  localparam int CW = $clog2(CYC_LEN + 1);

  logic          wen, wpen, busy, cs_q, pend, pend_wpen;
  logic [1:0]    bp, pend_bp;
  logic [CW-1:0] cnt;
  logic          blk_hit, hw_lock, cs_rise, arr_start, cyc_end;
  logic          unused_bits;

  assign unused_bits = ^{sr_din[6:4], sr_din[1:0]};

  always_comb begin
    case (bp)
      2'b00:   blk_hit = 1'b0;
      2'b01:   blk_hit = &chk_addr[AW-1:AW-2];
      2'b10:   blk_hit = chk_addr[AW-1];
      default: blk_hit = 1'b1;
    endcase
  end

  assign hw_lock   = ~wp_n & wpen;
  assign sreg_ok   = wen & ~busy & ~hw_lock;
  assign arr_ok    = wen & ~busy & ~blk_hit;
  assign cs_rise   = cs_n & ~cs_q;
  assign arr_start = arr_go & wen & ~busy;
  assign cyc_end   = busy && (cnt == '0);
  assign stat_byte = busy ? 8'hFF : {wpen, 3'b000, bp, wen, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen       <= 1'b0;
      wpen      <= WPEN_INIT;
      bp        <= BP_INIT;
      busy      <= 1'b0;
      cnt       <= '0;
      cs_q      <= 1'b1;
      pend      <= 1'b0;
      pend_wpen <= 1'b0;
      pend_bp   <= 2'b00;
    end else begin
      cs_q <= cs_n;
      if (cyc_end) begin
        busy <= 1'b0;
        wen  <= 1'b0;
        if (pend) begin
          wpen <= pend_wpen;
          bp   <= pend_bp;
          pend <= 1'b0;
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end else begin
        if ((cs_rise && pend) || arr_start) begin
          busy <= 1'b1;
          cnt  <= CW'(CYC_LEN - 1);
        end
        if (wrdi_stb)      wen <= 1'b0;
        else if (wren_stb) wen <= 1'b1;
        if (wrsr_stb && !cs_n && sreg_ok) begin
          pend      <= 1'b1;
          pend_wpen <= sr_din[7];
          pend_bp   <= sr_din[3:2];
        end else if (pend && !cs_n && hw_lock) begin
          pend <= 1'b0;
        end
      end
    end
  end

  p_wen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_byte[1] |-> (!arr_ok && !sreg_ok));
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && stat_byte[7] && !stat_byte[0]) |-> !sreg_ok);
  p_bits_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({wpen, bp}));
  p_busy_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[0] |-> (!arr_ok && !sreg_ok));
  p_end_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wen);
  p_wrdi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_stb && !busy) |=> !wen);
  p_go_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wen) |=> !busy);
endmodule

// File: tb/sreg_guard_test.sv
module sreg_guard_test;
  localparam int AW = 15;
  localparam int L  = 12;

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1;
  logic wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, arr_go = 0;
  logic [7:0] sr_din = 0;
  logic [AW-1:0] chk_addr = 0;
  logic [7:0] stat_byte, stat2;
  logic arr_ok, sreg_ok, arr_ok2, sreg_ok2;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  sreg_guard #(.AW(AW), .CYC_LEN(L)) uut (
    .clk, .rst_n, .cs_n, .wp_n, .wren_stb, .wrdi_stb, .wrsr_stb, .sr_din,
    .arr_go, .chk_addr, .stat_byte, .arr_ok, .sreg_ok);

  sreg_guard #(.AW(AW), .CYC_LEN(L), .BP_INIT(2'b11), .WPEN_INIT(1'b1)) uut2 (
    .clk, .rst_n, .cs_n, .wp_n, .wren_stb, .wrdi_stb, .wrsr_stb, .sr_din,
    .arr_go, .chk_addr, .stat_byte(stat2), .arr_ok(arr_ok2), .sreg_ok(sreg_ok2));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_wren();
    @(negedge clk) wren_stb = 1;
    @(negedge clk) wren_stb = 0;
  endtask

  task automatic pulse_wrdi();
    @(negedge clk) wrdi_stb = 1;
    @(negedge clk) wrdi_stb = 0;
  endtask

  task automatic sr_write(input logic [7:0] d, input bit drop_wp);
    @(negedge clk) begin cs_n = 0; wrsr_stb = 1; sr_din = d; end
    @(negedge clk) begin wrsr_stb = 0; if (drop_wp) wp_n = 0; end
    @(negedge clk) cs_n = 1;
    @(negedge clk);
  endtask

  task automatic ride_cycle(input string req, input logic [7:0] after);
    chk({req, " busy at start"}, stat_byte, 8'hFF);
    repeat (L - 1) @(negedge clk);
    chk({req, " busy at last clock"}, stat_byte, 8'hFF);
    @(negedge clk);
    chk({req, " status after cycle"}, stat_byte, after);
  endtask

  task automatic t_reset();
    chk("R1 status", stat_byte, 8'h00);
    chk("R1 loaded status", stat2, 8'h8C);
    chk("R4 perms after reset", {6'b0, arr_ok, sreg_ok}, 8'h00);
  endtask

  task automatic t_enable();
    pulse_wren();
    chk("R2 wren", stat_byte, 8'h02);
    chk("R3 level 00 addr 7FFF", {7'b0, arr_ok}, 8'h01);
    chk("R4 status ok when enabled", {7'b0, sreg_ok}, 8'h01);
    wp_n = 0;
    pulse_wrdi();
    chk("R2 wrdi with wp low", stat_byte, 8'h00);
    chk("R4 no perms when disabled", {6'b0, arr_ok, sreg_ok}, 8'h00);
    wp_n = 1;
    pulse_wren();
  endtask

  task automatic t_status_write();
    sr_write(8'hF7, 0);
    chk("R8 array perm in cycle", {6'b0, arr_ok, sreg_ok}, 8'h00);
    @(negedge clk) begin wren_stb = 1; cs_n = 0; wrsr_stb = 1; sr_din = 8'h0C; end
    @(negedge clk) begin wren_stb = 0; wrsr_stb = 0; cs_n = 1; end
    repeat (L - 3) @(negedge clk);
    chk("R8 busy at last clock", stat_byte, 8'hFF);
    @(negedge clk);
    chk("R6 R9 only bits 7,3,2 taken", stat_byte, 8'h84);
  endtask

  task automatic t_ranges();
    pulse_wren();
    chk_addr = 15'h5FFF; #1;
    chk("R3 quarter below", {7'b0, arr_ok}, 8'h01);
    chk_addr = 15'h6000; #1;
    chk("R3 quarter edge", {7'b0, arr_ok}, 8'h00);
    sr_write(8'h08, 0);
    ride_cycle("R6 half", 8'h08);
    pulse_wren();
    chk_addr = 15'h3FFF; #1;
    chk("R3 half below", {7'b0, arr_ok}, 8'h01);
    chk_addr = 15'h4000; #1;
    chk("R3 half edge", {7'b0, arr_ok}, 8'h00);
    sr_write(8'h0C, 0);
    ride_cycle("R6 all", 8'h0C);
    pulse_wren();
    chk_addr = 15'h0000; #1;
    chk("R3 all addr 0", {7'b0, arr_ok}, 8'h00);
    sr_write(8'h00, 0);
    ride_cycle("R6 none", 8'h00);
  endtask

  task automatic t_lock();
    wp_n = 0;
    pulse_wren();
    chk("R5 pin ignored when unarmed", {7'b0, sreg_ok}, 8'h01);
    sr_write(8'h80, 0);
    ride_cycle("R6 arm", 8'h80);
    pulse_wren();
    chk("R5 locked status", {7'b0, sreg_ok}, 8'h00);
    chk("R5 unprotected writable", {7'b0, arr_ok}, 8'h01);
    sr_write(8'h00, 0);
    chk("R5 locked write ignored", stat_byte, 8'h82);
    wp_n = 1;
  endtask

  task automatic t_cancel();
    sr_write(8'h0C, 1);
    chk("R7 dropped write", stat_byte, 8'h82);
    @(negedge clk);
    chk("R7 still no cycle", stat_byte, 8'h82);
    wp_n = 1;
  endtask

  task automatic t_array();
    @(negedge clk) arr_go = 1;
    @(negedge clk) arr_go = 0;
    ride_cycle("R10 R9 array cycle", 8'h80);
    @(negedge clk) arr_go = 1;
    @(negedge clk) arr_go = 0;
    chk("R10 go without enable", stat_byte, 8'h80);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_status_write();
    t_ranges();
    t_lock();
    t_cancel();
    t_array();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule